// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Port

This block is the serial front end of a small register bank. It listens on a two-wire bus (clock line and data line), both sampled in the system clock domain. It recognises start, repeated-start and stop conditions and answers to one of two fixed 7-bit bus addresses; a single select pin picks which one. It then moves bytes between the bus master and a bank of ten byte-wide registers. The block holds no register contents itself. It issues a one-cycle write strobe carrying an address and a data byte. For reads it issues a one-cycle read request carrying an address and takes the byte back on `rd_data` in the following cycle.

A write transaction carries a pointer byte first and data bytes after it. A read transaction returns bytes starting from the register that follows the last one accessed. The pointer moves forward after every data byte and wraps from the top register back to the bottom. The data line is driven only through an open-drain enable that pulls the line low. All bus timing comes from an external master at rates well below the system clock.

Top module: `twsi_regport`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal 0001111 when `addr_sel` is 1, or 0001000 when `addr_sel` is 0. The lowest bit of that byte selects read (1) or write (0). SDA is only ever pulled low while SCL is low.
- R2: An address byte that does not match is not acknowledged. Until the next START the slave never drives SDA and raises neither `wr_stb` nor `rd_req`.
- R3: In a write transaction, the first byte after the address is loaded into the register pointer and produces no write strobe.
- R4: Each later written byte, taken MSB first, produces exactly one single-cycle `wr_stb` after its acknowledge. The strobe carries `wr_addr` equal to the pointer and `wr_data` equal to the byte, and the pointer then moves up by one.
- R5: A pointer of 9 moves to 0 on its next advance, for both writes and reads.
- R6: A pointer byte with a value above 9 loads the pointer with 0.
- R7: A read transaction raises a single-cycle `rd_req` with `rd_addr` equal to the pointer, latches `rd_data` in the next cycle and shifts it out MSB first. It begins at the current pointer, which is the address after the last byte accessed, and advances with wraparound after each byte the master acknowledges.
- R8: A master NACK on a read byte ends the read: no further `rd_req`, and SDA stays released until STOP or START.
- R9: A START at any point, including in the middle of a byte, restarts address reception without a write strobe or pointer change. A STOP returns the slave to idle.
- R10: While `rst_n` is low the slave releases SDA, holds `wr_stb` and `rd_req` low and clears the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Chooses which of the two bus addresses is answered |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Byte to write |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 4 | Register address of the read |
| rd_data | input | 8 | Register byte, valid the cycle after `rd_req` |

## Verification
The bench targets both ends of the pointer range. Pointer bytes of 9, 10 and FFh must land on addresses 9, 0 and 0. A design that compared against the wrong limit, or kept the low nibble of an out-of-range byte, would strobe register 10, 12 or 15. Reads are checked right after a write, so they must come from the following address and wrap from 9 to 0; an off-by-one in the increment returns the byte just written. The wrong-address, NACK and mid-byte repeated-START cases catch a slave that still pulls SDA low, keeps requesting reads after the master gives up, or turns a half-received byte into a strobe.

// File: rtl/twsi_pkg.sv
package twsi_pkg;

    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 4;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RLOAD,
        ST_RHOLD,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } twsi_state_t;

    typedef struct packed {
        logic              stb;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } twsi_wr_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] last);
        return (p >= last) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_clamp(input logic [BYTE_W-1:0] b,
                                                   input logic [PTR_W-1:0]  last);
        return (b > BYTE_W'(last)) ? '0 : b[PTR_W-1:0];
    endfunction

endpackage

// File: rtl/twsi_sync.sv
module twsi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b1;
            else        chain[s] <= chain[s-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/twsi_ptr.sv
module twsi_ptr
    import twsi_pkg::*;
#(
    parameter logic [PTR_W-1:0] LAST_ADDR = 4'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              adv,
    output logic [PTR_W-1:0]  ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= ptr_clamp(load_byte, LAST_ADDR);
        else if (adv)  ptr <= ptr_next(ptr, LAST_ADDR);
    end
endmodule

// File: rtl/twsi_engine.sv
module twsi_engine
    import twsi_pkg::*;
#(
    parameter logic [6:0] SLV_HI = 7'h0F,
    parameter logic [6:0] SLV_LO = 7'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              addr_sel,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic              ptr_adv,
    output logic [BYTE_W-1:0] load_byte,
    output twsi_wr_t          wr_evt,
    output logic              rd_req,
    output twsi_state_t       state,
    output logic              start_det
);
    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

    logic                stop_det;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   tx;
    logic                rw;
    logic                first;
    logic [6:0]          own_addr;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign own_addr  = addr_sel ? SLV_HI : SLV_LO;
    assign load_byte = shreg;

    logic bus_evt;
    assign bus_evt  = start_det | stop_det;
    assign ptr_load = !bus_evt && state == ST_WACK && scl_fall && first;
    assign ptr_adv  = !bus_evt && ((state == ST_WACK && scl_fall && !first) ||
                                   state == ST_RLOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '0;
            sda_oe <= 1'b0;
            rw     <= 1'b0;
            first  <= 1'b0;
            rd_req <= 1'b0;
            wr_evt <= '0;
        end else begin
            rd_req     <= 1'b0;
            wr_evt.stb <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
                first  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + BITCNT_W'(1);
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (shreg[BYTE_W-1:1] == own_addr) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise && rw) begin
                            rd_req <= 1'b1;
                            state  <= ST_RLOAD;
                        end else if (scl_fall) begin
                            sda_oe <= 1'b0;
                            first  <= 1'b1;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + BITCNT_W'(1);
                        end else if (scl_fall && cnt == FULL) begin
                            cnt    <= '0;
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                            first  <= 1'b0;
                            if (!first) begin
                                wr_evt.stb  <= 1'b1;
                                wr_evt.addr <= ptr;
                                wr_evt.data <= shreg;
                            end
                        end
                    end
                    ST_RLOAD: begin
                        tx    <= rd_data;
                        state <= ST_RHOLD;
                    end
                    ST_RHOLD: begin
                        if (scl_fall) begin
                            sda_oe <= ~tx[BYTE_W-1];
                            cnt    <= '0;
                            state  <= ST_RDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + BITCNT_W'(1);
                        end else if (scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (!sda_lvl) begin
                                rd_req <= 1'b1;
                                state  <= ST_RLOAD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twsi_regport.sv
module twsi_regport
    import twsi_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [PTR_W-1:0] LAST_ADDR   = 4'd9,
    parameter logic [6:0]       SLV_HI      = 7'h0F,
    parameter logic [6:0]       SLV_LO      = 7'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_in, line_lvl, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twsi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_in[g]),
            .lvl  (line_lvl[g]),
            .rise (line_rise[g]),
            .fall (line_fall[g])
        );
    end

    logic              scl_lvl;
    logic              ptr_load, ptr_adv, start_det;
    logic [BYTE_W-1:0] load_byte;
    logic [PTR_W-1:0]  ptr;
    twsi_wr_t          wr_evt;
    twsi_state_t       state;

    assign scl_lvl = line_lvl[0];

    twsi_engine #(.SLV_HI(SLV_HI), .SLV_LO(SLV_LO)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .scl_rise (line_rise[0]),
        .scl_fall (line_fall[0]),
        .sda_lvl  (line_lvl[1]),
        .sda_rise (line_rise[1]),
        .sda_fall (line_fall[1]),
        .addr_sel (addr_sel),
        .ptr      (ptr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr_load (ptr_load),
        .ptr_adv  (ptr_adv),
        .load_byte(load_byte),
        .wr_evt   (wr_evt),
        .rd_req   (rd_req),
        .state    (state),
        .start_det(start_det)
    );

    twsi_ptr #(.LAST_ADDR(LAST_ADDR)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_byte(load_byte),
        .adv      (ptr_adv),
        .ptr      (ptr)
    );

    assign wr_stb  = wr_evt.stb;
    assign wr_addr = wr_evt.addr;
    assign wr_data = wr_evt.data;
    assign rd_addr = ptr;
endmodule

// File: rtl/twsi_regport_chk.sv
module twsi_regport_chk
    import twsi_pkg::*;
#(
    parameter logic [PTR_W-1:0] LAST_ADDR = 4'd9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             wr_stb,
    input logic [PTR_W-1:0] wr_addr,
    input logic             rd_req,
    input logic [PTR_W-1:0] rd_addr,
    input logic             scl_lvl,
    input twsi_state_t      state,
    input logic [PTR_W-1:0] ptr,
    input logic             ptr_adv,
    input logic             start_det
);
    assert_pull_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_lvl));

    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !wr_stb && !rd_req));

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr <= LAST_ADDR));

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && ptr == LAST_ADDR) |=> (ptr == '0));

    assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_rd_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr <= LAST_ADDR));

    assert_restart_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && !sda_oe && !wr_stb));
endmodule

bind twsi_regport twsi_regport_chk #(.LAST_ADDR(LAST_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .scl_lvl  (scl_lvl),
    .state    (state),
    .ptr      (ptr),
    .ptr_adv  (ptr_adv),
    .start_det(start_det)
);

// File: tb/twsi_regport_tb.sv
module twsi_regport_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       addr_sel = 1'b1;
    logic       sda_oe, wr_stb, rd_req;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    wire        sda_bus = !(m_low | sda_oe);

    logic [7:0] bank     [16];
    logic [7:0] exp_bank [16];
    int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
    logic [3:0] last_wa;
    logic [7:0] last_wd;
    int total = 0, bad = 0;

    // sel | ptr | data | expected address
    localparam logic [20:0] VEC [0:5] = '{
        21'h103A53, 21'h0095A9, 21'h10C3C0,
        21'h0FFC30, 21'h10A960, 21'h0077E7
    };

    always #5 clk = ~clk;

    twsi_regport u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(8'h40 + i * 19);
    endfunction

    assign rd_data = bank[rd_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= init_val(i);
        end else if (wr_stb) begin
            bank[wr_addr] <= wr_data;
            last_wa <= wr_addr;
            last_wd <= wr_data;
            wr_cnt  <= wr_cnt + 1;
        end
        if (rd_req) rd_cnt <= rd_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; hq(); scl = 1'b1; hq(); b = sda_bus; hq(); scl = 1'b0; hq();
    endtask

    task automatic bus_start();
        m_low = 1'b0; hq(); scl = 1'b1; hq(); m_low = 1'b1; hq(); scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hq(); scl = 1'b1; hq(); m_low = 1'b0; hq(); hq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    function automatic logic [7:0] adr_byte(input logic sel, input logic rd);
        return {(sel ? 7'h0F : 7'h08), rd};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] d;
        int w0, r0, o0;
        for (int i = 0; i < 16; i++) exp_bank[i] = init_val(i);
        repeat (5) @(negedge clk);
        // R10 reset state
        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 wr_stb", wr_stb, 0);
        chk("R10 rd_req", rd_req, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: pointer is 0 after reset, first read returns register 0
        bus_start();
        send_byte(adr_byte(1'b1, 1'b1), ack);
        chk("R1 ack read", ack, 0);
        recv_byte(1'b1, d);
        chk("R10 read reg0", d, exp_bank[0]);
        bus_stop();

        // vector table: pointer load, one data byte, read of next address
        for (int v = 0; v < 6; v++) begin
            logic       sel;
            logic [7:0] p, dat;
            logic [3:0] ea;
            string      tag;
            sel = VEC[v][20]; p = VEC[v][19:12]; dat = VEC[v][11:4]; ea = VEC[v][3:0];
            tag = (p > 8'd9) ? "R6" : "R3";
            addr_sel = sel;
            w0 = wr_cnt;
            bus_start();
            send_byte(adr_byte(sel, 1'b0), ack);
            chk("R1 ack write", ack, 0);
            send_byte(p, ack);
            chk({tag, " no strobe on pointer"}, wr_cnt - w0, 0);
            send_byte(dat, ack);
            bus_stop();
            exp_bank[ea] = dat;
            chk({tag, " one strobe"}, wr_cnt - w0, 1);
            chk({tag, " wr_addr"}, last_wa, ea);
            chk("R4 wr_data", last_wd, dat);
            bus_start();
            send_byte(adr_byte(sel, 1'b1), ack);
            recv_byte(1'b1, d);
            bus_stop();
            chk("R7 R5 read next", d, exp_bank[(ea == 4'd9) ? 0 : ea + 1]);
        end

        // R2: wrong address is ignored
        addr_sel = 1'b1;
        w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
        bus_start();
        send_byte(adr_byte(1'b0, 1'b0), ack);
        chk("R2 nack", ack, 1);
        send_byte(8'h04, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        chk("R2 no strobe", wr_cnt - w0, 0);
        chk("R2 no drive", oe_cnt - o0, 0);
        addr_sel = 1'b0;
        bus_start();
        send_byte(adr_byte(1'b1, 1'b1), ack);
        bus_stop();
        chk("R2 other address with sel low", ack, 1);
        chk("R2 no read", rd_cnt - r0, 0);

        // R4 R5: burst write across the top address
        addr_sel = 1'b1;
        bus_start();
        send_byte(adr_byte(1'b1, 1'b0), ack);
        send_byte(8'h08, ack);
        send_byte(8'h11, ack);
        chk("R4 burst addr 8", last_wa, 8);
        send_byte(8'h22, ack);
        chk("R4 burst addr 9", last_wa, 9);
        send_byte(8'h33, ack);
        chk("R5 burst wraps to 0", last_wa, 0);
        chk("R4 burst data", last_wd, 8'h33);
        bus_stop();
        exp_bank[8] = 8'h11; exp_bank[9] = 8'h22; exp_bank[0] = 8'h33;

        // R7 R8: burst read with repeated START, then NACK
        r0 = rd_cnt;
        bus_start();
        send_byte(adr_byte(1'b1, 1'b0), ack);
        send_byte(8'h08, ack);
        bus_start();
        send_byte(adr_byte(1'b1, 1'b1), ack);
        recv_byte(1'b0, d);
        chk("R7 burst read 8", d, exp_bank[8]);
        recv_byte(1'b0, d);
        chk("R7 burst read 9", d, exp_bank[9]);
        recv_byte(1'b1, d);
        chk("R5 burst read wraps", d, exp_bank[0]);
        chk("R7 read requests", rd_cnt - r0, 3);
        o0 = oe_cnt;
        recv_byte(1'b1, d);
        chk("R8 released after nack", d, 8'hFF);
        chk("R8 no request after nack", rd_cnt - r0, 3);
        chk("R8 no drive after nack", oe_cnt - o0, 0);
        bus_stop();

        // R9: repeated START in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        send_byte(adr_byte(1'b1, 1'b0), ack);
        send_byte(8'h02, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(adr_byte(1'b1, 1'b1), ack);
        chk("R9 readdress ack", ack, 0);
        recv_byte(1'b1, d);
        bus_stop();
        chk("R9 partial byte not written", wr_cnt - w0, 0);
        chk("R9 pointer kept", d, exp_bank[2]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule